// File: doc/BRIEF.md
# Character Display Instruction Controller

This block sits behind a host bus adapter and carries out the instruction set of a two-line, forty-column dot-matrix character display. Every host access arrives as a one-cycle strobe with a register-select bit, a read/write bit and a data byte. The block keeps the address counter, the choice between the display-data RAM and the glyph-definition RAM, the entry, display, cursor and blink flags, the horizontal shift offset, the brightness code and the busy flag. Both RAMs sit inside as small arrays.

Reads return a byte on `rd_data` one cycle after the strobe. The flags, the cursor address, the shift offset, the brightness code and a blink phase go out to a renderer, which lies outside this block. A data byte written straight after a function-set command is taken as a brightness setting and does not reach RAM. The clear command blanks the whole display RAM one location per cycle while busy is high.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset, display, cursor and blink are off (0), the interface flag `bus_8bit` is 1, `bright_code` is 0, the shift offset is 0, and a clear runs with `busy` high.
- R2: Command 01h starts a clear. It writes 20h to all 2*LINE_LEN display locations, one per cycle, and holds `busy` high for exactly 2*LINE_LEN cycles. It also sets the address counter to 0, selects display RAM, zeroes the shift offset and forces increment mode.
- R3: While `busy` is high, every access except a status read is ignored. A status read during busy returns 1 in bit 7.
- R4: Commands 02h and 03h set the address counter to 0, select display RAM and zero the shift offset. RAM is not touched.
- R5: In display RAM the counter runs 00h..27h then 40h..67h then back to 00h when incrementing, and in the reverse order when decrementing. Entry command 04h..07h sets bit 1 for increment and bit 0 for display shift.
- R6: Command 40h..7Fh selects glyph RAM and loads bits 5:0 into the counter. In glyph RAM the counter wraps over 6 bits (3Fh to 00h).
- R7: A display-RAM write with the shift bit set moves the offset by one: left (offset+1 mod LINE_LEN) when incrementing, right (offset-1 mod LINE_LEN) when decrementing. The counter still steps. Reads and glyph-RAM accesses never change the offset.
- R8: Command 10h..1Fh with bit 3 = 0 moves the counter one place, right if bit 2 = 1 and left if bit 2 = 0. With bit 3 = 1 it shifts the offset (left = +1, right = -1 mod LINE_LEN) and leaves the counter unchanged.
- R9: Command 80h..FFh loads bits 6:0 into the counter and selects display RAM only when bits 5:0 are below LINE_LEN. Otherwise it is ignored.
- R10: Command 20h..3Fh copies bit 4 to `bus_8bit` and arms brightness. The next data write (RS=1) sets `bright_code` from bits 1:0 and does not write RAM. Any command write in between disarms it, and the data then goes to RAM.
- R11: A status read (RS=0, R/W=1) returns busy in bit 7 and the address counter in bits 6:0. A data read (RS=1, R/W=1) returns the selected RAM byte and then steps the counter.
- R12: Command 08h..0Fh sets display (bit 2), cursor (bit 1) and blink (bit 0). While blink is on, `blink_phase` toggles every BLINK_HALF cycles. While blink is off it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_rs | input | 1 | 0 = instruction/status, 1 = data |
| acc_rw | input | 1 | 0 = write, 1 = read |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read result, valid the cycle after a read strobe |
| busy | output | 1 | Clear in progress |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| blink_phase | output | 1 | Blink phase for the cursor cell |
| bus_8bit | output | 1 | Interface width flag |
| bright_code | output | 2 | Brightness code, 0 = full |
| shift_ofs | output | 6 | Display shift offset, 0..LINE_LEN-1 |
| cursor_addr | output | 7 | Address counter |

## Verification
The hardest state to reach is the ignore window of a clear. Commands, data writes and status polls have to land while the fill is still running, and their effect can only be seen once the fill is over. The bench issues a clear and, inside the 80-cycle window, sends a display-off command and a data write, then polls status. After busy falls it checks that the flags are unchanged, that the location written earlier reads back blank, and that a counter left in decrement mode now increments. The brightness path is reached by setting the counter to a known cell first, which makes it visible that the armed byte did not land in RAM.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL, OP_SHIFT,
    OP_FUNC, OP_SETCG, OP_SETDD, OP_WDATA, OP_RDATA, OP_STATUS
  } op_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;

  // One-step move of the shift offset, modulo len
  function automatic logic [5:0] ofs_move(input logic [5:0] ofs, input logic left,
                                          input int unsigned len);
    logic [5:0] last;
    last = 6'(len - 1);
    if (left) return (ofs == last) ? 6'd0 : ofs + 6'd1;
    else      return (ofs == 6'd0) ? last : ofs - 6'd1;
  endfunction

endpackage

// File: rtl/cdisp_decode.sv
module cdisp_decode
  import cdisp_pkg::*;
(
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] d,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (rw) begin
      op = rs ? OP_RDATA : OP_STATUS;
    end else if (rs) begin
      op = OP_WDATA;
    end else if (d[7]) op = OP_SETDD;
    else if (d[6])     op = OP_SETCG;
    else if (d[5])     op = OP_FUNC;
    else if (d[4])     op = OP_SHIFT;
    else if (d[3])     op = OP_DISPCTL;
    else if (d[2])     op = OP_ENTRY;
    else if (d[1])     op = OP_HOME;
    else if (d[0])     op = OP_CLEAR;
  end
endmodule

// File: rtl/cdisp_addr_step.sv
module cdisp_addr_step #(
  parameter int LINE_LEN = 40
) (
  input  logic [6:0] ac,
  input  logic       cg_sel,
  input  logic       up,
  output logic [6:0] nxt
);
  localparam logic [5:0] LAST_COL = 6'(LINE_LEN - 1);

  logic [5:0] col;
  logic       line;

  assign col  = ac[5:0];
  assign line = ac[6];

  always_comb begin
    if (cg_sel) begin
      nxt = {1'b0, up ? col + 6'd1 : col - 6'd1};
    end else if (up) begin
      nxt = (col == LAST_COL) ? {~line, 6'd0} : {line, col + 6'd1};
    end else begin
      nxt = (col == 6'd0) ? {~line, LAST_COL} : {line, col - 6'd1};
    end
  end
endmodule

// File: rtl/cdisp_ram.sv
module cdisp_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import cdisp_pkg::*;
#(
  parameter int LINE_LEN   = 40,
  parameter int BLINK_HALF = 125_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_rs,
  input  logic       acc_rw,
  input  logic [7:0] acc_wdata,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       blink_phase,
  output logic       bus_8bit,
  output logic [1:0] bright_code,
  output logic [5:0] shift_ofs,
  output logic [6:0] cursor_addr
);
  localparam int DD_CHARS = 2 * LINE_LEN;
  localparam int DD_AW    = $clog2(DD_CHARS);
  localparam int CG_DEPTH = 64;
  localparam int CG_AW    = $clog2(CG_DEPTH);
  localparam int BLINK_W  = $clog2(BLINK_HALF) + 1;
  localparam logic [DD_AW-1:0]   FILL_LAST  = DD_AW'(DD_CHARS - 1);
  localparam logic [BLINK_W-1:0] BLINK_LAST = BLINK_W'(BLINK_HALF - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  logic [6:0]         ac_q, ac_d;
  logic               sel_cg_q, sel_cg_d;
  logic               inc_q, inc_d, shen_q, shen_d;
  logic               disp_q, disp_d, cur_q, cur_d, blk_q, blk_d;
  logic               if8_q, if8_d;
  logic [1:0]         bri_q, bri_d;
  logic               pend_q, pend_d;
  logic [5:0]         ofs_q, ofs_d;
  logic               clr_q, clr_d;
  logic [DD_AW-1:0]   fill_q, fill_d;
  logic [7:0]         rd_q, rd_d;
  logic [BLINK_W-1:0] bcnt_q, bcnt_d;
  logic               bph_q, bph_d;

  // decode and address stepping
  op_e        op;
  logic       step_up;
  logic [6:0] ac_step;

  cdisp_decode u_dec (.rs(acc_rs), .rw(acc_rw), .d(acc_wdata), .op(op));

  assign step_up = (op == OP_SHIFT) ? acc_wdata[2] : inc_q;

  cdisp_addr_step #(.LINE_LEN(LINE_LEN)) u_step (
    .ac(ac_q), .cg_sel(sel_cg_q), .up(step_up), .nxt(ac_step)
  );

  // RAM ports
  logic             dd_we, cg_we;
  logic [DD_AW-1:0] dd_waddr, dd_idx;
  logic [7:0]       dd_wdata, dd_rdata, cg_rdata;

  assign dd_idx = ac_q[6] ? DD_AW'(LINE_LEN) + DD_AW'(ac_q[5:0]) : DD_AW'(ac_q[5:0]);

  cdisp_ram #(.DEPTH(DD_CHARS), .DW(8)) u_ddram (
    .clk(clk), .we(dd_we), .waddr(dd_waddr), .wdata(dd_wdata),
    .raddr(dd_idx), .rdata(dd_rdata)
  );

  cdisp_ram #(.DEPTH(CG_DEPTH), .DW(8)) u_cgram (
    .clk(clk), .we(cg_we), .waddr(ac_q[CG_AW-1:0]), .wdata(acc_wdata),
    .raddr(ac_q[CG_AW-1:0]), .rdata(cg_rdata)
  );

  // next state
  always_comb begin
    ac_d = ac_q;  sel_cg_d = sel_cg_q;  inc_d = inc_q;  shen_d = shen_q;
    disp_d = disp_q;  cur_d = cur_q;  blk_d = blk_q;  if8_d = if8_q;
    bri_d = bri_q;  pend_d = pend_q;  ofs_d = ofs_q;  clr_d = clr_q;
    fill_d = fill_q;  rd_d = rd_q;
    dd_we = 1'b0;  dd_waddr = dd_idx;  dd_wdata = acc_wdata;  cg_we = 1'b0;

    if (clr_q) begin
      dd_we    = 1'b1;
      dd_waddr = fill_q;
      dd_wdata = BLANK_CODE;
      fill_d   = fill_q + 1'b1;
      if (fill_q == FILL_LAST) clr_d = 1'b0;
    end

    if (acc_valid) begin
      if (op == OP_STATUS) begin
        rd_d = {clr_q, ac_q};
      end else if (!clr_q) begin
        if (!acc_rw) pend_d = 1'b0;
        case (op)
          OP_CLEAR: begin
            clr_d = 1'b1;  fill_d = '0;  ac_d = '0;
            sel_cg_d = 1'b0;  ofs_d = '0;  inc_d = 1'b1;
          end
          OP_HOME: begin
            ac_d = '0;  sel_cg_d = 1'b0;  ofs_d = '0;
          end
          OP_ENTRY: begin
            inc_d = acc_wdata[1];  shen_d = acc_wdata[0];
          end
          OP_DISPCTL: begin
            disp_d = acc_wdata[2];  cur_d = acc_wdata[1];  blk_d = acc_wdata[0];
          end
          OP_SHIFT: begin
            if (acc_wdata[3]) ofs_d = ofs_move(ofs_q, ~acc_wdata[2], LINE_LEN);
            else              ac_d  = ac_step;
          end
          OP_FUNC: begin
            if8_d = acc_wdata[4];  pend_d = 1'b1;
          end
          OP_SETCG: begin
            ac_d = {1'b0, acc_wdata[5:0]};  sel_cg_d = 1'b1;
          end
          OP_SETDD: begin
            if (acc_wdata[5:0] < 6'(LINE_LEN)) begin
              ac_d = acc_wdata[6:0];  sel_cg_d = 1'b0;
            end
          end
          OP_WDATA: begin
            if (pend_q) begin
              bri_d = acc_wdata[1:0];
            end else if (sel_cg_q) begin
              cg_we = 1'b1;  ac_d = ac_step;
            end else begin
              dd_we = 1'b1;  ac_d = ac_step;
              if (shen_q) ofs_d = ofs_move(ofs_q, inc_q, LINE_LEN);
            end
          end
          OP_RDATA: begin
            rd_d = sel_cg_q ? cg_rdata : dd_rdata;
            ac_d = ac_step;
          end
          default: ;
        endcase
      end
    end

    // blink phase generator
    if (!blk_d) begin
      bcnt_d = '0;  bph_d = 1'b0;
    end else if (bcnt_q == BLINK_LAST) begin
      bcnt_d = '0;  bph_d = ~bph_q;
    end else begin
      bcnt_d = bcnt_q + 1'b1;  bph_d = bph_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ac_q <= '0;  sel_cg_q <= 1'b0;  inc_q <= 1'b1;  shen_q <= 1'b0;
      disp_q <= 1'b0;  cur_q <= 1'b0;  blk_q <= 1'b0;  if8_q <= 1'b1;
      bri_q <= 2'b00;  pend_q <= 1'b0;  ofs_q <= '0;  clr_q <= 1'b1;
      fill_q <= '0;  rd_q <= '0;  bcnt_q <= '0;  bph_q <= 1'b0;
    end else begin
      ac_q <= ac_d;  sel_cg_q <= sel_cg_d;  inc_q <= inc_d;  shen_q <= shen_d;
      disp_q <= disp_d;  cur_q <= cur_d;  blk_q <= blk_d;  if8_q <= if8_d;
      bri_q <= bri_d;  pend_q <= pend_d;  ofs_q <= ofs_d;  clr_q <= clr_d;
      fill_q <= fill_d;  rd_q <= rd_d;  bcnt_q <= bcnt_d;  bph_q <= bph_d;
    end
  end

  assign rd_data     = rd_q;
  assign busy        = clr_q;
  assign disp_on     = disp_q;
  assign cursor_on   = cur_q;
  assign blink_on    = blk_q;
  assign blink_phase = bph_q;
  assign bus_8bit    = if8_q;
  assign bright_code = bri_q;
  assign shift_ofs   = ofs_q;
  assign cursor_addr = ac_q;
endmodule

// File: rtl/cdisp_checker.sv
module cdisp_checker #(
  parameter int LINE_LEN = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_rs,
  input logic       acc_rw,
  input logic [7:0] acc_wdata,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       disp_on,
  input logic       blink_on,
  input logic       blink_phase,
  input logic [1:0] bright_code,
  input logic [5:0] shift_ofs,
  input logic [6:0] cursor_addr,
  input logic       sel_cg
);
  // R11: status read reports the busy flag seen at the strobe
  a_r11_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_rs && acc_rw) |=> (rd_data[7] == $past(busy)));

  // R3: writes during busy change nothing visible
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc_valid && !acc_rw) |=> ($stable(disp_on) && $stable(bright_code)
                                        && $stable(shift_ofs) && $stable(cursor_addr)));

  // R2: busy only rises after a clear command
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acc_valid && !acc_rs && !acc_rw && acc_wdata == 8'h01));

  // R7 / R8: offset stays in range
  a_r8_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < 6'(LINE_LEN));

  // R5 / R9: display-RAM counter always points at a real column
  a_r5_dd_col: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cg |-> (cursor_addr[5:0] < 6'(LINE_LEN)));

  // R6: glyph-RAM counter is six bits wide
  a_r6_cg_width: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cg |-> !cursor_addr[6]);

  // R12: no blink phase while blink is off
  a_r12_blink_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_on |-> !blink_phase);
endmodule

bind chardisp_ctrl cdisp_checker #(.LINE_LEN(LINE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rs(acc_rs),
  .acc_rw(acc_rw), .acc_wdata(acc_wdata), .rd_data(rd_data), .busy(busy),
  .disp_on(disp_on), .blink_on(blink_on), .blink_phase(blink_phase),
  .bright_code(bright_code), .shift_ofs(shift_ofs), .cursor_addr(cursor_addr),
  .sel_cg(sel_cg_q)
);

// File: tb/tb_chardisp_ctrl.sv
module tb_chardisp_ctrl;
  localparam int LINE_LEN = 40;
  localparam int BHALF    = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_rs, acc_rw;
  logic [7:0] acc_wdata;
  logic [7:0] rd_data;
  logic       busy, disp_on, cursor_on, blink_on, blink_phase, bus_8bit;
  logic [1:0] bright_code;
  logic [5:0] shift_ofs;
  logic [6:0] cursor_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  chardisp_ctrl #(.LINE_LEN(LINE_LEN), .BLINK_HALF(BHALF)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rs(acc_rs),
    .acc_rw(acc_rw), .acc_wdata(acc_wdata), .rd_data(rd_data), .busy(busy),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .blink_phase(blink_phase), .bus_8bit(bus_8bit), .bright_code(bright_code),
    .shift_ofs(shift_ofs), .cursor_addr(cursor_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rs, input logic rw, input logic [7:0] d);
    acc_valid = 1'b1; acc_rs = rs; acc_rw = rw; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);   access(1'b0, 1'b0, d); endtask
  task automatic wdat(input logic [7:0] d);  access(1'b1, 1'b0, d); endtask

  task automatic status(output logic [7:0] v);
    access(1'b0, 1'b1, 8'h00); v = rd_data;
  endtask

  task automatic rdat(output logic [7:0] v);
    access(1'b1, 1'b1, 8'h00); v = rd_data;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 busy at reset", busy, 1);
    chk("R1 disp_on", disp_on, 0);
    chk("R1 cursor_on", cursor_on, 0);
    chk("R1 blink_on", blink_on, 0);
    chk("R1 bus_8bit", bus_8bit, 1);
    chk("R1 bright_code", bright_code, 0);
    chk("R1 shift_ofs", shift_ofs, 0);
    wait_ready();
    chk("R1 clear finished", busy, 0);
    status(v);
    chk("R11 status after reset", v, 8'h00);
    cmd(8'hE7); rdat(v);
    chk("R1 location 67h blank", v, 8'h20);
  endtask

  task automatic t_dd_wrap();
    logic [7:0] v;
    cmd(8'h06);
    cmd(8'hA7); wdat(8'h41); status(v);
    chk("R5 inc 27h->40h", v, 8'h40);
    cmd(8'hE7); wdat(8'h42); status(v);
    chk("R5 inc 67h->00h", v, 8'h00);
    cmd(8'h04);
    cmd(8'hC0); wdat(8'h43); status(v);
    chk("R5 dec 40h->27h", v, 8'h27);
    cmd(8'h80); wdat(8'h44); status(v);
    chk("R5 dec 00h->67h", v, 8'h67);
    cmd(8'h06); cmd(8'hA7); rdat(v);
    chk("R11 read 27h data", v, 8'h41);
    status(v);
    chk("R11 read steps counter", v, 8'h40);
  endtask

  task automatic t_cg_wrap();
    logic [7:0] v;
    cmd(8'h06);
    cmd(8'h7F); wdat(8'h55); status(v);
    chk("R6 cg wrap 3Fh->00h", v, 8'h00);
    cmd(8'h7F); rdat(v);
    chk("R6 cg readback", v, 8'h55);
    status(v);
    chk("R6 cg read wrap", v, 8'h00);
  endtask

  task automatic t_disp_shift();
    logic [7:0] v;
    cmd(8'h02);
    chk("R4 home ofs", shift_ofs, 0);
    chk("R4 home addr", cursor_addr, 0);
    cmd(8'h07); wdat(8'h61);
    chk("R7 inc write shifts left", shift_ofs, 1);
    chk("R7 counter still steps", cursor_addr, 7'h01);
    cmd(8'h05); wdat(8'h62);
    chk("R7 dec write shifts right", shift_ofs, 0);
    wdat(8'h63);
    chk("R7 ofs wraps to 39", shift_ofs, 39);
    chk("R5 dec wrap addr", cursor_addr, 7'h67);
    rdat(v);
    chk("R7 read keeps offset", shift_ofs, 39);
    chk("R11 read 67h", v, 8'h42);
    chk("R7 read steps counter", cursor_addr, 7'h66);
    cmd(8'h7F); wdat(8'h11);
    chk("R7 cg write no shift", shift_ofs, 39);
    cmd(8'h02);
    chk("R4 home clears ofs", shift_ofs, 0);
    cmd(8'h80); rdat(v);
    chk("R4 home keeps RAM", v, 8'h63);
  endtask

  task automatic t_shift_cmd();
    cmd(8'h02);
    cmd(8'h14);
    chk("R8 cursor right", cursor_addr, 7'h01);
    cmd(8'h10);
    chk("R8 cursor left", cursor_addr, 7'h00);
    cmd(8'h10);
    chk("R8 cursor left wrap", cursor_addr, 7'h67);
    cmd(8'h18);
    chk("R8 display left", shift_ofs, 1);
    chk("R8 display shift keeps addr", cursor_addr, 7'h67);
    cmd(8'h1C);
    chk("R8 display right", shift_ofs, 0);
    cmd(8'h1C);
    chk("R8 display right wrap", shift_ofs, 39);
  endtask

  task automatic t_bad_dd();
    logic [7:0] v;
    cmd(8'h90); status(v);
    chk("R9 valid set", v, 8'h10);
    cmd(8'hA8); status(v);
    chk("R9 column 40 ignored", v, 8'h10);
    cmd(8'hFF); status(v);
    chk("R9 column 63 ignored", v, 8'h10);
  endtask

  task automatic t_bright();
    logic [7:0] v;
    cmd(8'h06);
    cmd(8'h85); cmd(8'h30); wdat(8'h03);
    chk("R10 brightness set", bright_code, 3);
    chk("R10 counter untouched", cursor_addr, 7'h05);
    rdat(v);
    chk("R10 RAM untouched", v, 8'h20);
    cmd(8'h20);
    chk("R10 4-bit flag", bus_8bit, 0);
    cmd(8'h85); wdat(8'h01);
    chk("R10 skipped after command", bright_code, 3);
    cmd(8'h85); rdat(v);
    chk("R10 byte went to RAM", v, 8'h01);
    cmd(8'h30);
    chk("R10 8-bit flag", bus_8bit, 1);
    cmd(8'h00);
  endtask

  task automatic t_dispctl();
    logic p0;
    cmd(8'h0F);
    chk("R12 display on", disp_on, 1);
    chk("R12 cursor on", cursor_on, 1);
    chk("R12 blink on", blink_on, 1);
    repeat (3) @(negedge clk);
    p0 = blink_phase;
    repeat (BHALF) @(negedge clk);
    chk("R12 phase toggles", blink_phase, int'(!p0));
    cmd(8'h0A);
    chk("R12 cursor only", {disp_on, cursor_on, blink_on}, 3'b010);
    chk("R12 phase off", blink_phase, 0);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    int n;
    cmd(8'h80); wdat(8'h5A);
    cmd(8'h04); cmd(8'h18); cmd(8'h0C);
    cmd(8'h01);
    cmd(8'h08);
    chk("R3 display cmd ignored", disp_on, 1);
    wdat(8'h77);
    chk("R3 data ignored", cursor_addr, 0);
    status(v);
    chk("R3 status during busy", v, 8'h80);
    wait_ready();
    chk("R2 ofs zero", shift_ofs, 0);
    status(v);
    chk("R2 counter zero", v, 8'h00);
    rdat(v);
    chk("R2 location 00h blanked", v, 8'h20);
    chk("R2 increment forced", cursor_addr, 7'h01);
    cmd(8'hA7); rdat(v);
    chk("R2 location 27h blanked", v, 8'h20);
    cmd(8'h01);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R2 busy length", n, 2 * LINE_LEN);
  endtask

  initial begin
    acc_valid = 1'b0; acc_rs = 1'b0; acc_rw = 1'b0; acc_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dd_wrap();
    t_cg_wrap();
    t_disp_shift();
    t_shift_cmd();
    t_bad_dd();
    t_bright();
    t_dispctl();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule